// File: doc/BRIEF.md
# Composite-basis AES-128 round engine

This block encrypts one 128-bit block with a 128-bit key and spends one clock cycle per round. The state register never holds a standard-basis byte. On entry the plaintext and each round key go byte by byte through a linear change of basis into the tower field GF((2^4)^2). That field is built from nibble arithmetic modulo y^4+y+1, and its extension polynomial is x^2+x+λ, where λ is the inverse of y. All S-box inversions, the affine step, the column mixing and the key additions are done in that basis. Only the finished ciphertext is mapped back.

Round keys come from outside. The core drives a round index, and the surrounding logic answers combinationally with the matching 128-bit round key in standard byte order. A start pulse loads the plaintext while round key 0 is presented. One round then follows on each clock. A one-cycle completion pulse marks the point where the ciphertext register becomes valid.

Top module: `cf_aes_enc`

## Requirements
- R1: While reset is asserted and after it is released, done_o, busy_o and rnd_o are 0 and cipher_o is all zeros.
- R2: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the ciphertext is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: With key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734, the ciphertext is 3925841d02dc09fbdc118597196a0b32.
- R4: When start_i is sampled high while idle, rnd_o is 0 in that cycle. rnd_o is then 1, 2, …, 10 in the ten cycles that follow, and done_o is high in the eleventh cycle after the start edge.
- R5: done_o is high for exactly one cycle per encryption, and rnd_o and busy_o are 0 in that cycle.
- R6: start_i is ignored while busy_o is high. The running encryption finishes with its own result, and no second completion follows.
- R7: cipher_o keeps its value from one completion until the next completion.
- R8: Byte 0 of every 128-bit port sits in bits 127:120. Bytes 4c..4c+3 form state column c, and row r is shifted left by r columns.
- R9: The tenth round skips the column mixing, and the all-zero key with the all-zero plaintext gives 66e94bd4ef8a2c3b884cfa59ca342b2e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an encryption; sampled only when idle |
| plain_i | input | 128 | Plaintext block, standard basis |
| rkey_i | input | 128 | Round key selected by rnd_o, standard basis |
| rnd_o | output | 4 | Index of the round key needed this cycle (0..10) |
| busy_o | output | 1 | Encryption in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cipher_o | output | 128 | Ciphertext, standard basis, held until the next completion |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a run. If the core took it, the state would be reloaded with a different plaintext while the key stream kept advancing. The bench raises start_i with the inverted plaintext in the fourth round of a run on a known vector. It then checks that the ciphertext still matches the vector, and that no extra completion appears in the cycles that follow. Any error in the basis maps, the tower inversion or the mapped doubling constant breaks all three known vectors at once. The all-zero vector also shows whether the tenth round is treated differently.

// File: rtl/cf_aes_pkg.sv
package cf_aes_pkg;

    localparam int BYTES    = 16;
    localparam int BLK_W    = 8 * BYTES;
    localparam logic [3:0] LAMBDA = 4'h9;   // y^-1 = y^3 + 1

    // nibble product modulo y^4 + y + 1
    function automatic logic [3:0] nib_mul(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] acc;
        logic [3:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'h3 : 4'h0);
        end
        return acc;
    endfunction

    // a^14 = a^-1 for nonzero a, 0 for 0
    function automatic logic [3:0] nib_inv(input logic [3:0] a);
        logic [3:0] a2, a4, a8;
        a2 = nib_mul(a, a);
        a4 = nib_mul(a2, a2);
        a8 = nib_mul(a4, a4);
        return nib_mul(nib_mul(a2, a4), a8);
    endfunction

    // tower element {hi, lo} = hi*beta + lo, beta^2 = beta + LAMBDA
    function automatic logic [7:0] cf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [3:0] hh;
        hh = nib_mul(a[7:4], b[7:4]);
        return {hh ^ nib_mul(a[7:4], b[3:0]) ^ nib_mul(a[3:0], b[7:4]),
                nib_mul(hh, LAMBDA) ^ nib_mul(a[3:0], b[3:0])};
    endfunction

    function automatic logic [7:0] cf_inv(input logic [7:0] a);
        logic [3:0] s, dlt, di;
        s   = a[3:0] ^ a[7:4];
        dlt = nib_mul(a[3:0], s) ^ nib_mul(LAMBDA, nib_mul(a[7:4], a[7:4]));
        di  = nib_inv(dlt);
        return {nib_mul(a[7:4], di), nib_mul(s, di)};
    endfunction

    // matrix stored as eight column bytes, column i at [8i +: 8]
    function automatic logic [7:0] mat_apply(input logic [63:0] m, input logic [7:0] x);
        logic [7:0] acc;
        acc = '0;
        for (int i = 0; i < 8; i++)
            if (x[i]) acc = acc ^ m[8*i +: 8];
        return acc;
    endfunction

    // linear part of the standard S-box affine step
    function automatic logic [7:0] std_lin(input logic [7:0] b);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]};
    endfunction

    // tower element that satisfies z^8 + z^4 + z^3 + z + 1 = 0
    function automatic logic [7:0] find_root();
        logic [7:0] res, p2, p3, p4, p8;
        res = 8'h00;
        for (int c = 2; c < 256; c++) begin
            p2 = cf_mul(c[7:0], c[7:0]);
            p3 = cf_mul(p2, c[7:0]);
            p4 = cf_mul(p2, p2);
            p8 = cf_mul(p4, p4);
            if (res == 8'h00 && (p8 ^ p4 ^ p3 ^ c[7:0] ^ 8'h01) == 8'h00)
                res = c[7:0];
        end
        return res;
    endfunction

    function automatic logic [63:0] build_fwd();
        logic [63:0] m;
        logic [7:0]  r, p;
        r = find_root();
        p = 8'h01;
        for (int i = 0; i < 8; i++) begin
            m[8*i +: 8] = p;
            p = cf_mul(p, r);
        end
        return m;
    endfunction

    function automatic logic [63:0] build_inv(input logic [63:0] fwd);
        logic [63:0] m;
        m = '0;
        for (int j = 0; j < 8; j++)
            for (int b = 0; b < 256; b++)
                if (mat_apply(fwd, b[7:0]) == (8'h01 << j))
                    m[8*j +: 8] = b[7:0];
        return m;
    endfunction

    function automatic logic [63:0] build_aff(input logic [63:0] fwd, input logic [63:0] inv);
        logic [63:0] m;
        for (int j = 0; j < 8; j++)
            m[8*j +: 8] = mat_apply(fwd, std_lin(mat_apply(inv, 8'h01 << j)));
        return m;
    endfunction

    localparam logic [63:0] MAP_FWD = build_fwd();
    localparam logic [63:0] MAP_INV = build_inv(MAP_FWD);
    localparam logic [63:0] AFF_MAT = build_aff(MAP_FWD, MAP_INV);
    localparam logic [7:0]  AFF_CST = mat_apply(MAP_FWD, 8'h63);
    localparam logic [7:0]  DBL_CST = MAP_FWD[15:8];   // image of 0x02

endpackage

// File: rtl/cf_basis_map.sv
module cf_basis_map
    import cf_aes_pkg::*;
#(
    parameter int          NBYTE = 16,
    parameter logic [63:0] MAT   = 64'h0
) (
    input  logic [8*NBYTE-1:0] vec_i,
    output logic [8*NBYTE-1:0] vec_o
);
    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        assign vec_o[8*k +: 8] = mat_apply(MAT, vec_i[8*k +: 8]);
    end
endmodule

// File: rtl/cf_sbox.sv
module cf_sbox
    import cf_aes_pkg::*;
(
    input  logic [7:0] x_i,
    output logic [7:0] y_o
);
    logic [7:0] inv_d;

    assign inv_d = cf_inv(x_i);
    assign y_o   = mat_apply(AFF_MAT, inv_d) ^ AFF_CST;

    // R2
    always_comb begin
        if (x_i != 8'h00) begin
            inv_chk: assert (cf_mul(x_i, inv_d) == 8'h01);
        end
    end
endmodule

// File: rtl/cf_mixcol.sv
module cf_mixcol
    import cf_aes_pkg::*;
(
    input  logic [31:0] col_i,
    output logic [31:0] col_o
);
    logic [7:0] s_d [4];
    logic [7:0] d_d [4];

    for (genvar r = 0; r < 4; r++) begin : g_row
        assign s_d[r] = col_i[31-8*r -: 8];
        assign d_d[r] = cf_mul(s_d[r], DBL_CST);
    end

    for (genvar r = 0; r < 4; r++) begin : g_out
        // 2*s[r] ^ 3*s[r+1] ^ s[r+2] ^ s[r+3], with 3*x = 2*x ^ x
        assign col_o[31-8*r -: 8] = d_d[r] ^ d_d[(r+1)%4] ^ s_d[(r+1)%4]
                                  ^ s_d[(r+2)%4] ^ s_d[(r+3)%4];
    end
endmodule

// File: rtl/cf_aes_enc.sv
module cf_aes_enc
    import cf_aes_pkg::*;
#(
    parameter  int NR = 10,
    localparam int RW = $clog2(NR + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [127:0]     plain_i,
    input  logic [127:0]     rkey_i,
    output logic [RW-1:0]    rnd_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [127:0]     cipher_o
);
    typedef struct packed {
        logic          busy;
        logic [RW-1:0] rnd;
        logic          done;
        logic [127:0]  st;
        logic [127:0]  ct;
    } core_t;

    localparam logic [RW-1:0] LAST = RW'(NR);

    core_t cur_q, nxt_d;

    logic [127:0] pmap_d, kmap_d, sub_d, shf_d, mix_d, rres_d, post_d, ctmap_d;
    logic         last_d;

    cf_basis_map #(.NBYTE(BYTES), .MAT(MAP_FWD)) u_pmap (.vec_i(plain_i), .vec_o(pmap_d));
    cf_basis_map #(.NBYTE(BYTES), .MAT(MAP_FWD)) u_kmap (.vec_i(rkey_i),  .vec_o(kmap_d));

    for (genvar k = 0; k < BYTES; k++) begin : g_sub
        cf_sbox u_sbox (.x_i(cur_q.st[127-8*k -: 8]), .y_o(sub_d[127-8*k -: 8]));
    end

    // byte (row r, column c) takes byte (r, c+r)
    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            assign shf_d[127-8*(4*c+r) -: 8] = sub_d[127-8*(4*((c+r)%4)+r) -: 8];
        end
        cf_mixcol u_mix (.col_i(shf_d[127-32*c -: 32]), .col_o(mix_d[127-32*c -: 32]));
    end

    assign last_d = (cur_q.rnd == LAST);
    assign rres_d = last_d ? shf_d : mix_d;
    assign post_d = rres_d ^ kmap_d;

    cf_basis_map #(.NBYTE(BYTES), .MAT(MAP_INV)) u_omap (.vec_i(post_d), .vec_o(ctmap_d));

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        if (!cur_q.busy) begin
            if (start_i) begin
                nxt_d.st   = pmap_d ^ kmap_d;
                nxt_d.rnd  = RW'(1);
                nxt_d.busy = 1'b1;
            end
        end else begin
            nxt_d.st = post_d;
            if (last_d) begin
                nxt_d.busy = 1'b0;
                nxt_d.rnd  = '0;
                nxt_d.done = 1'b1;
                nxt_d.ct   = ctmap_d;
            end else begin
                nxt_d.rnd = cur_q.rnd + RW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign rnd_o    = cur_q.rnd;
    assign busy_o   = cur_q.busy;
    assign done_o   = cur_q.done;
    assign cipher_o = cur_q.ct;

    // R5
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R5
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && rnd_o == '0));
    // R4
    rnd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rnd_o <= LAST);
    // R4
    rnd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && rnd_o != LAST) |=> (busy_o && rnd_o == $past(rnd_o) + RW'(1)));
    // R6
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && rnd_o == LAST) |=> (done_o && !busy_o));
    // R7
    ct_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && rnd_o == LAST) |=> $stable(cipher_o));
endmodule

// File: tb/cf_aes_enc_bench.sv
module cf_aes_enc_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] plain = '0;
    logic [127:0] rkey;
    logic [3:0]   rnd;
    logic         busy, done;
    logic [127:0] cipher;

    logic [127:0] rk [0:10];
    int           n_run = 0, n_fail = 0;
    bit           ended = 0;
    logic [127:0] exp_q [$];
    string        tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rkey = (rnd <= 4'd10) ? rk[rnd] : '0;

    cf_aes_enc u_cf_aes_enc (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .plain_i(plain),
        .rkey_i(rkey), .rnd_o(rnd), .busy_o(busy), .done_o(done), .cipher_o(cipher)
    );

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= a;
            a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
        end
        return p;
    endfunction

    function automatic logic [7:0] sb(input logic [7:0] b);
        logic [7:0] v = 0;
        for (int y = 1; y < 256; y++)
            if (gmul(b, y[7:0]) == 8'h01) v = y[7:0];
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    task automatic expand(input logic [127:0] key);
        logic [31:0] w [0:43];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {sb(t[23:16]) ^ rc, sb(t[15:8]), sb(t[7:0]), sb(t[31:24])};
                rc = gmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // driver: pushes expected result, steps through one encryption
    task automatic run_vec(input logic [127:0] key, input logic [127:0] pt,
                           input logic [127:0] ct, input string tag, input bit inject);
        expand(key);
        exp_q.push_back(ct);
        tag_q.push_back(tag);
        plain = pt;
        start = 1'b1;
        check(rnd == 4'd0 && !busy, "R4 idle index", {124'd0, rnd}, 128'd0);
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= 10; i++) begin
            check(rnd == i[3:0] && !done && busy, "R4 round index", {124'd0, rnd}, 128'(i));
            if (inject && i == 3) begin
                start = 1'b1;
                plain = ~pt;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        check(done == 1'b1 && rnd == 4'd0 && !busy, "R4 done timing", {127'd0, done}, 128'd1);
        @(negedge clk);
        check(done == 1'b0, "R5 single pulse", {127'd0, done}, 128'd0);
        for (int i = 0; i < 4; i++) @(negedge clk);
        check(cipher == ct, "R7 hold", cipher, ct);
        if (inject) check(!busy && !done && exp_q.size() == 0, "R6 no restart",
                          {127'd0, busy}, 128'd0);
    endtask

    // monitor: compares each completion against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done === 1'b1) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected completion", cipher, 128'd0);
                end else begin
                    logic [127:0] e;
                    string        t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(cipher === e, t, cipher, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "watchdog", 128'd0, 128'd1);
        finish_run();
    end

    initial begin
        for (int r = 0; r < 11; r++) rk[r] = '0;
        repeat (3) @(negedge clk);
        check(!done && !busy && rnd == 0 && cipher == 0, "R1 reset", cipher, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !busy && rnd == 0 && cipher == 0, "R1 after release", cipher, 128'd0);
        // R2 and R8: standard byte order through the core
        run_vec(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
                128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 R8 vector", 1'b0);
        // R3
        run_vec(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
                128'h3925841d02dc09fbdc118597196a0b32, "R3 vector", 1'b0);
        // R9
        run_vec(128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R9 zero vector", 1'b0);
        // R6: start raised mid-run with another plaintext
        run_vec(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
                128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R6 vector", 1'b1);
        repeat (15) @(negedge clk);
        check(exp_q.size() == 0 && !done, "R6 queue drained", {127'd0, done}, 128'd0);
        finish_run();
    end
endmodule